// File: doc/BRIEF.md
# Center-Aligned Up/Down Counter

This block is the time base of a symmetric PWM timer. When enabled it counts up from zero to the active reload value, turns round and counts back down to zero, then turns round again. Each turning point lasts one clock and repeats no count value. The counter flags an update event at the top (overflow) and at the bottom (underflow) of every cycle. Software can force a restart at any time with an update-generate request. This clears the counter, sets the direction to up, loads the reload register and flags an update event. Issuing this request just before enabling the counter is the recommended way to start it.

Software may also overwrite the count while the counter runs. The new direction then depends on the value written:
- Writing zero sets the direction to up.
- Writing exactly the active reload value sets the direction to down.
- Writing any other value keeps the current direction. For example, a counter that was counting up and receives a value above the reload keeps counting up. It wraps through the top of the counter range back to zero and then resumes its normal cycle.

A counter write never flags an update event.

The reload value goes through a preload register. With preloading off, a reload write takes effect on the next edge. With preloading on, it waits for the next update event. The direction is held in a two-state machine:
- ST_COUNT_UP moves to ST_COUNT_DOWN on the top turn (TURN_TOP) or on a write of the reload value (WR_AT_RELOAD).
- ST_COUNT_DOWN moves to ST_COUNT_UP on the bottom turn (TURN_BOTTOM), on a write of zero (WR_AT_ZERO), or on an update-generate request (RESTART). RESTART also forces ST_COUNT_UP from ST_COUNT_UP.

Top module: `ca_updown_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), the update-event output is 0 and the active reload value is all ones.
- R2: When enabled and not at a turning point, the count rises by one per clock while counting up and falls by one while counting down. Counting up from the all-ones value wraps to 0.
- R3: When enabled, counting up and the count equals a non-zero active reload value, the next count is reload minus 1. The direction becomes down (direction output 1) and the update-event output is 1 for that one cycle.
- R4: When enabled, counting down, the count is 0 and the active reload value is non-zero, the next count is 1. The direction becomes up (direction output 0) and the update-event output is 1 for that one cycle.
- R5: With an active reload value of 0, a counter at 0 holds at 0 in either direction and flags no update event.
- R6: A counter write of a value other than 0 and other than the active reload value loads that value on the next edge and leaves the direction unchanged. This includes values above the reload value.
- R7: A counter write of 0 sets the direction to up; a counter write equal to the active reload value sets it to down. The value is loaded on the next edge. Zero takes precedence when the reload value is also 0.
- R8: A counter write never raises the update-event output, and it takes effect whether or not the counter is enabled.
- R9: An update-generate request, regardless of enable, sets the count to 0 and the direction to up on the next edge. It raises the update-event output for one cycle and takes precedence over a counter write in the same cycle.
- R10: With enable low and neither a write nor an update-generate request, the count and direction hold and the update-event output stays 0.
- R11: A reload write always updates the preload register. The active reload value is loaded from the preload register (including a write in the same cycle) on every edge when preloading is off, and only on an update event (R3, R4, R9) when it is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable |
| ug_req | input | 1 | Software update-generate request |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | CNT_W | Value written to the counter |
| arr_wr_en | input | 1 | Reload register write strobe |
| arr_wr_data | input | CNT_W | Value written to the reload preload register |
| arr_preload_en | input | 1 | 1: reload value applied at update events; 0: applied immediately |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | Direction, 1 = counting down |
| uev_o | output | 1 | One-cycle update-event flag |

## Verification
The bound checker checks the following relations on every cycle:
- Single-step movement in the recorded direction.
- The hold while disabled.
- The restart after an update-generate request.
- The silence of update events after counter writes.
- The direction set by a write of zero.
- The reversal of direction that accompanies every counting event.

Some behaviours depend on the hidden active reload value, so only the bench scenarios can show them:
- The exact turning points.
- The hold at a zero reload.
- The direction chosen for a write equal to the reload value.
- The deferred reload under preloading.

The bench covers these by comparing every cycle against a reference model.

// File: rtl/ca_cnt_pkg.sv
package ca_cnt_pkg;

    typedef enum logic [0:0] {
        ST_COUNT_UP   = 1'b0,
        ST_COUNT_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic [2:0] {
        STEP_RESTART,
        STEP_LOAD,
        STEP_IDLE,
        STEP_TURN,
        STEP_FLAT,
        STEP_MOVE
    } cnt_step_e;

endpackage

// File: rtl/ca_reload_reg.sv
module ca_reload_reg #(
    parameter int          W         = 16,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         preload_en,
    input  logic         load_evt,
    output logic [W-1:0] reload_act
);

    logic [W-1:0] pre_q;
    logic [W-1:0] pre_nxt;
    logic [W-1:0] act_q;
    logic         act_load;

    always_comb begin
        pre_nxt  = wr_en ? wr_data : pre_q;
        act_load = !preload_en || load_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= RESET_VAL;
            act_q <= RESET_VAL;
        end else begin
            pre_q <= pre_nxt;
            if (act_load) begin
                act_q <= pre_nxt;
            end
        end
    end

    assign reload_act = act_q;

endmodule

// File: rtl/ca_dir_fsm.sv
module ca_dir_fsm
    import ca_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     wr_en,
    input  logic     wr_is_zero,
    input  logic     wr_is_reload,
    input  logic     turn_top,
    input  logic     turn_bottom,
    output cnt_dir_e state,
    output logic     dir_down
);

    cnt_dir_e state_q;
    cnt_dir_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_COUNT_UP;                       // RESTART
        end else if (wr_en) begin
            if (wr_is_zero) begin
                state_d = ST_COUNT_UP;                   // WR_AT_ZERO
            end else if (wr_is_reload) begin
                state_d = ST_COUNT_DOWN;                 // WR_AT_RELOAD
            end
        end else begin
            unique case (state_q)
                ST_COUNT_UP: begin
                    if (turn_top) state_d = ST_COUNT_DOWN;   // TURN_TOP
                end
                ST_COUNT_DOWN: begin
                    if (turn_bottom) state_d = ST_COUNT_UP;  // TURN_BOTTOM
                end
                default: state_d = ST_COUNT_UP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COUNT_UP;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        dir_down = (state_q == ST_COUNT_DOWN);
    end

endmodule

// File: rtl/ca_cnt_core.sv
module ca_cnt_core
    import ca_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload_act,
    input  cnt_dir_e     state,
    output logic [W-1:0] cnt,
    output logic         turn_top,
    output logic         turn_bottom,
    output logic         wr_is_zero,
    output logic         wr_is_reload,
    output logic         uev
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         uev_q;
    logic         quiet;
    logic         reload_zero;
    logic         cnt_zero;
    logic         at_reload;
    cnt_step_e    step;

    always_comb begin
        quiet        = !restart && !wr_en;
        reload_zero  = (reload_act == '0);
        cnt_zero     = (cnt_q == '0);
        at_reload    = (cnt_q == reload_act);
        wr_is_zero   = (wr_data == '0);
        wr_is_reload = (wr_data == reload_act);
        turn_top     = quiet && en && (state == ST_COUNT_UP)
                       && at_reload && !reload_zero;
        turn_bottom  = quiet && en && (state == ST_COUNT_DOWN)
                       && cnt_zero && !reload_zero;
    end

    // classify the step taken this cycle
    always_comb begin
        if (restart)                          step = STEP_RESTART;
        else if (wr_en)                       step = STEP_LOAD;
        else if (!en)                         step = STEP_IDLE;
        else if (turn_top || turn_bottom)     step = STEP_TURN;
        else if (reload_zero && cnt_zero)     step = STEP_FLAT;
        else                                  step = STEP_MOVE;
    end

    always_comb begin
        unique case (step)
            STEP_RESTART: cnt_d = '0;
            STEP_LOAD:    cnt_d = wr_data;
            STEP_IDLE:    cnt_d = cnt_q;
            STEP_TURN:    cnt_d = turn_top ? (reload_act - ONE) : ONE;
            STEP_FLAT:    cnt_d = cnt_q;
            STEP_MOVE:    cnt_d = (state == ST_COUNT_DOWN) ? (cnt_q - ONE)
                                                           : (cnt_q + ONE);
            default:      cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uev_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            uev_q <= restart || turn_top || turn_bottom;
        end
    end

    assign cnt = cnt_q;
    assign uev = uev_q;

endmodule

// File: rtl/ca_updown_counter.sv
module ca_updown_counter
    import ca_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             ug_req,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             arr_wr_en,
    input  logic [CNT_W-1:0] arr_wr_data,
    input  logic             arr_preload_en,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             uev_o
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    logic [CNT_W-1:0] reload_act;
    logic             turn_top;
    logic             turn_bottom;
    logic             wr_is_zero;
    logic             wr_is_reload;
    logic             load_evt;
    cnt_dir_e         dir_state;

    assign load_evt = ug_req || turn_top || turn_bottom;

    ca_reload_reg #(
        .W         (CNT_W),
        .RESET_VAL (RELOAD_RST)
    ) u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (arr_wr_en),
        .wr_data    (arr_wr_data),
        .preload_en (arr_preload_en),
        .load_evt   (load_evt),
        .reload_act (reload_act)
    );

    ca_cnt_core #(
        .W (CNT_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (cnt_en),
        .restart      (ug_req),
        .wr_en        (cnt_wr_en),
        .wr_data      (cnt_wr_data),
        .reload_act   (reload_act),
        .state        (dir_state),
        .cnt          (count_o),
        .turn_top     (turn_top),
        .turn_bottom  (turn_bottom),
        .wr_is_zero   (wr_is_zero),
        .wr_is_reload (wr_is_reload),
        .uev          (uev_o)
    );

    ca_dir_fsm u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (ug_req),
        .wr_en        (cnt_wr_en),
        .wr_is_zero   (wr_is_zero),
        .wr_is_reload (wr_is_reload),
        .turn_top     (turn_top),
        .turn_bottom  (turn_bottom),
        .state        (dir_state),
        .dir_down     (dir_down_o)
    );

endmodule

// File: rtl/ca_updown_counter_chk.sv
module ca_updown_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             ug_req,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic             dir_down_o,
    input logic             uev_o
);

    AST_MOVE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_en && !ug_req && !cnt_wr_en) && !uev_o && (count_o != $past(count_o)))
        |-> (count_o == ($past(dir_down_o) ? CNT_W'($past(count_o) - 1'b1)
                                           : CNT_W'($past(count_o) + 1'b1)))); // R2

    AST_EVENT_REVERSES: assert property (@(posedge clk) disable iff (!rst_n)
        (uev_o && !$past(ug_req)) |-> (dir_down_o != $past(dir_down_o))); // R3

    AST_WRITE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr_en && !ug_req) |-> (!uev_o && count_o == $past(cnt_wr_data))); // R8

    AST_WRITE_ZERO_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr_en && !ug_req && cnt_wr_data == '0) |-> !dir_down_o); // R7

    AST_SOFT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ug_req) |-> (count_o == '0 && !dir_down_o && uev_o)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cnt_en && !ug_req && !cnt_wr_en)
        |-> ($stable(count_o) && $stable(dir_down_o) && !uev_o)); // R10

endmodule

bind ca_updown_counter ca_updown_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .ug_req      (ug_req),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .count_o     (count_o),
    .dir_down_o  (dir_down_o),
    .uev_o       (uev_o)
);

// File: tb/ca_updown_counter_test.sv
`timescale 1ns/1ps
module ca_updown_counter_test;

    localparam int W = 16;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         ug_req = 1'b0;
    logic         cnt_wr_en = 1'b0;
    logic [W-1:0] cnt_wr_data = '0;
    logic         arr_wr_en = 1'b0;
    logic [W-1:0] arr_wr_data = '0;
    logic         arr_preload_en = 1'b0;
    logic [W-1:0] count_o;
    logic         dir_down_o;
    logic         uev_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // reference model state
    logic [W-1:0] m_cnt = '0;
    logic         m_down = 1'b0;
    logic         m_uev = 1'b0;
    logic [W-1:0] m_arr = ALL1;
    logic [W-1:0] m_pre = ALL1;

    always #4 clk = ~clk;   // 125 MHz

    ca_updown_counter #(.CNT_W(W)) uut (
        .clk (clk), .rst_n (rst_n), .cnt_en (cnt_en), .ug_req (ug_req),
        .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
        .arr_wr_en (arr_wr_en), .arr_wr_data (arr_wr_data),
        .arr_preload_en (arr_preload_en),
        .count_o (count_o), .dir_down_o (dir_down_o), .uev_o (uev_o)
    );

    function automatic string step_tag(input logic en, input logic ug, input logic wr,
                                       input logic [W-1:0] wd, input logic aw);
        if (ug) return "R9";
        if (wr) return (wd == '0 || wd == m_arr) ? "R7" : "R6";
        if (aw) return "R11";
        if (!en) return "R10";
        if (m_arr == '0 && m_cnt == '0) return "R5";
        if (!m_down && m_cnt == m_arr) return "R3";
        if (m_down && m_cnt == '0) return "R4";
        return "R2";
    endfunction

    // one clock of the reference model, inputs as sampled at the edge
    task automatic model_step(input logic en, input logic ug, input logic wr,
                              input logic [W-1:0] wd, input logic aw,
                              input logic [W-1:0] ad, input logic pe);
        logic [W-1:0] pre_n;
        logic top, bot;
        pre_n = aw ? ad : m_pre;
        top = !ug && !wr && en && !m_down && m_cnt == m_arr && m_arr != '0;
        bot = !ug && !wr && en &&  m_down && m_cnt == '0 && m_arr != '0;
        if (ug) begin
            m_cnt = '0; m_down = 1'b0; m_uev = 1'b1;
        end else if (wr) begin
            if (wd == '0) m_down = 1'b0;
            else if (wd == m_arr) m_down = 1'b1;
            m_cnt = wd; m_uev = 1'b0;
        end else if (!en) begin
            m_uev = 1'b0;
        end else if (top) begin
            m_cnt = m_arr - 1'b1; m_down = 1'b1; m_uev = 1'b1;
        end else if (bot) begin
            m_cnt = W'(1); m_down = 1'b0; m_uev = 1'b1;
        end else begin
            m_uev = 1'b0;
            if (!(m_arr == '0 && m_cnt == '0))
                m_cnt = m_down ? m_cnt - 1'b1 : m_cnt + 1'b1;
        end
        if (!pe || ug || top || bot) m_arr = pre_n;
        m_pre = pre_n;
    endtask

    task automatic check(input string tag, input logic [W-1:0] c, input logic d, input logic u);
        n_checks++;
        if (count_o !== c || dir_down_o !== d || uev_o !== u) begin
            n_fail++;
            $display("FAIL %s: actual cnt=%0d dir=%0b uev=%0b expected cnt=%0d dir=%0b uev=%0b",
                     tag, count_o, dir_down_o, uev_o, c, d, u);
        end
    endtask

    task automatic cyc(input logic en, input logic ug, input logic wr, input logic [W-1:0] wd,
                       input logic aw, input logic [W-1:0] ad, input logic pe);
        string tag;
        cnt_en = en; ug_req = ug; cnt_wr_en = wr; cnt_wr_data = wd;
        arr_wr_en = aw; arr_wr_data = ad; arr_preload_en = pe;
        tag = step_tag(en, ug, wr, wd, aw);
        @(posedge clk);
        model_step(en, ug, wr, wd, aw, ad, pe);
        @(negedge clk);
        check(tag, m_cnt, m_down, m_uev);
    endtask

    task automatic run(input int n, input logic pe);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, pe);
    endtask

    // watchdog
    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", '0, 1'b0, 1'b0);                      // reset state
        // R11: direct reload load with preloading off, counter idle
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, W'(4), 1'b0);
        check("R10", '0, 1'b0, 1'b0);
        // R9: restart before starting
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
        check("R9", '0, 1'b0, 1'b1);
        // R2 up to the reload, R3 top turn
        run(4, 1'b0);
        check("R2", W'(4), 1'b0, 1'b0);
        run(1, 1'b0);
        check("R3", W'(3), 1'b1, 1'b1);
        run(3, 1'b0);
        run(1, 1'b0);
        check("R4", W'(1), 1'b0, 1'b1);
        // R6: write above reload while counting up keeps up
        cyc(1'b1, 1'b0, 1'b1, W'(9), 1'b0, '0, 1'b0);
        check("R6", W'(9), 1'b0, 1'b0);
        // R7: write reload value sets down
        cyc(1'b1, 1'b0, 1'b1, W'(4), 1'b0, '0, 1'b0);
        check("R7", W'(4), 1'b1, 1'b0);
        run(2, 1'b0);
        // R7: write zero while down sets up
        cyc(1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0);
        check("R7", '0, 1'b0, 1'b0);
        // R6: write between 0 and reload while up keeps up
        cyc(1'b1, 1'b0, 1'b1, W'(2), 1'b0, '0, 1'b0);
        check("R6", W'(2), 1'b0, 1'b0);
        // R8: write while disabled, no event
        cyc(1'b0, 1'b0, 1'b1, W'(3), 1'b0, '0, 1'b0);
        check("R8", W'(3), 1'b0, 1'b0);
        // R10: hold while disabled
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        check("R10", W'(3), 1'b0, 1'b0);
        // R9: restart wins over a same-cycle write
        cyc(1'b1, 1'b1, 1'b1, W'(7), 1'b0, '0, 1'b0);
        check("R9", '0, 1'b0, 1'b1);
        // R11: preloaded reload 2 waits for the next event (top at 4)
        cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, W'(2), 1'b1);
        run(3, 1'b1);
        check("R11", W'(4), 1'b0, 1'b0);
        run(1, 1'b1);
        check("R11", W'(3), 1'b1, 1'b1);
        run(3, 1'b1);
        run(1, 1'b1);
        run(1, 1'b1);
        check("R11", W'(2), 1'b0, 1'b0);
        run(1, 1'b1);
        check("R3", W'(1), 1'b1, 1'b1);
        // R5: zero reload holds at zero
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b1, '0, 1'b1);
        run(3, 1'b1);
        check("R5", '0, 1'b0, 1'b0);
        // R2: wrap from all ones to zero while up
        cyc(1'b1, 1'b0, 1'b1, ALL1, 1'b1, W'(5), 1'b0);
        run(1, 1'b0);
        check("R2", '0, 1'b0, 1'b0);
        // constrained random
        for (int i = 0; i < 6000; i++) begin
            logic en, ug, wr, aw, pe;
            logic [W-1:0] wd, ad;
            int sel;
            en = ($urandom_range(0, 9) != 0);
            ug = ($urandom_range(0, 99) == 0);
            wr = ($urandom_range(0, 24) == 0);
            aw = ($urandom_range(0, 39) == 0);
            pe = (($urandom_range(0, 3)) != 0) ? arr_preload_en : ~arr_preload_en;
            ad = W'($urandom_range(0, 12));
            sel = $urandom_range(0, 4);
            case (sel)
                0: wd = '0;
                1: wd = m_arr;
                2: wd = m_arr + W'($urandom_range(1, 6));
                3: wd = W'($urandom_range(0, 12));
                default: wd = ALL1 - W'($urandom_range(0, 3));
            endcase
            cyc(en, ug, wr, wd, aw, ad, pe);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule